// File: doc/BRIEF.md
# Voice Codec Loopback Path Router

This block sits in the digital core of a voice codec, between the receive path (companded or linear data arriving from the PCM highway and headed for the D/A converter) and the transmit path (samples from the A/D converter headed back out to the PCM highway). It chooses how samples move between these two paths. In ordinary operation each path runs independently. Three test loops are also available. One returns converter data to the converter and leaves the digital side out. One returns receive data just before the D/A point. One returns receive data after the hybrid stage.

Each frame carries one sample per port. Every sample port has a valid strobe. A frame-sync pulse marks each frame boundary. The loop mode and the companding bypass take effect only at a frame-sync pulse. A transmit sample captured during one frame goes out at the next frame-sync pulse, so every transmit sample is encoded under one configuration. When the bypass is off, the external data is 8-bit mu-law and the block expands and compresses it. When the bypass is on, the external ports carry 16-bit two's-complement linear samples unchanged.

Top module: `vlb_router`

## Requirements
- R1: After reset the active mode is normal, the bypass is off, and `dac_valid` and `tx_pcm_valid` are low. A frame-sync pulse that ends a frame with no transmit sample produces no `tx_pcm_valid` pulse.
- R2: `mode_req` and `bypass_req` are sampled only in a cycle in which `frame_sync` is high. At all other times a change on them has no effect on routing or encoding.
- R3: Normal mode (mode code 2'b00): a receive sample appears on `dac_sample`, expanded, one cycle after `rx_pcm_valid`. An A/D sample captured in a frame leaves on `tx_pcm_data`, compressed, at the next frame sync.
- R4: Analog-test mode (code 2'b01): an A/D sample appears unchanged on `dac_sample` with `dac_valid` one cycle after `adc_valid`. The transmit output produces no sample for that frame.
- R5: Digital loop (code 2'b10): the expanded receive sample is sent to the D/A port and is also fed to the transmit encoder. At the next frame sync `tx_pcm_data` equals the receive code.
- R6: Full loop (code 2'b11): the D/A-side sample passes through one hybrid register stage into the transmit encoder. At the next frame sync `tx_pcm_data` equals the receive code.
- R7: With the bypass on, the 16-bit value on `rx_pcm_data` reaches `dac_sample` unchanged and an A/D value reaches `tx_pcm_data` unchanged. With the bypass off, PCM codes use bits [7:0] and the upper bits of `tx_pcm_data` are zero.
- R8: Compression follows mu-law: the magnitude is clipped at 32635, a bias of 132 is added, and the code is {sign, 3-bit segment, 4-bit mantissa} with every bit inverted. For example, 0 gives 8'hFF, +32767 gives 8'h80 and -32768 gives 8'h00.
- R9: Expansion inverts that mapping. 8'hFF gives 0, 8'h80 gives +32124 and 8'h00 gives -32124. The negative-zero code 8'h7F expands to 0, so it comes back through a loop as 8'hFF.
- R10: `tx_pcm_valid` is a single-cycle pulse. It is set only in the cycle after a frame-sync pulse, and only when a transmit sample was captured in the frame that just ended.
- R11: A sample captured in a frame goes out at the next sync encoded under that frame's mode and bypass, even when the same sync switches to a new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | One-cycle frame boundary pulse |
| mode_req | input | 2 | Requested loop mode, taken at frame sync |
| bypass_req | input | 1 | Requested companding bypass, taken at frame sync |
| rx_pcm_valid | input | 1 | Receive sample strobe |
| rx_pcm_data | input | 16 | Receive code in [7:0], or linear sample when bypassed |
| dac_valid | output | 1 | Strobe toward the D/A model |
| dac_sample | output | 16 | Linear sample toward the D/A model |
| adc_valid | input | 1 | Strobe from the A/D model |
| adc_sample | input | 16 | Linear sample from the A/D model |
| tx_pcm_valid | output | 1 | Transmit sample strobe, once per frame |
| tx_pcm_data | output | 16 | Transmit code in [7:0], or linear sample when bypassed |

## Verification
The bench changes mode and bypass at the same sync that releases a held sample. A design that applied the new setting early would send the old frame's sample in the wrong encoding or drop it. It sends the mu-law extremes and the negative-zero code around both digital loops. Clipping or bias errors show up as wrong codes, and a sign-handling error shows up when 8'h7F comes back as itself. Analog-test frames check that the transmit output stays silent. Changing `mode_req` in the middle of a frame must not change routing. A router that leaked converter data to transmit, or applied requests outside a sync, would produce stray or misrouted samples.

// File: rtl/vlb_pkg.sv
package vlb_pkg;
  localparam int LIN_W   = 16;
  localparam int PCM_W   = 8;
  localparam int MODE_W  = 2;
  localparam int MU_BIAS = 132;
  localparam int MU_CLIP = 32635;

  typedef enum logic [MODE_W-1:0] {
    LB_NORMAL  = 2'b00,
    LB_ATEST   = 2'b01,
    LB_DIGITAL = 2'b10,
    LB_FULL    = 2'b11
  } lb_mode_e;

  // linear two's complement -> inverted mu-law code
  function automatic logic [PCM_W-1:0] mu_compress(input logic [LIN_W-1:0] s);
    logic            neg;
    logic [LIN_W-1:0] mag;
    logic [2:0]      seg;
    logic [3:0]      man;
    int              sh;
    neg = s[LIN_W-1];
    mag = neg ? (~s + 1'b1) : s;
    if (mag > LIN_W'(MU_CLIP)) mag = LIN_W'(MU_CLIP);
    mag = mag + LIN_W'(MU_BIAS);
    casez (mag[14:7])
      8'b1???????: seg = 3'd7;
      8'b01??????: seg = 3'd6;
      8'b001?????: seg = 3'd5;
      8'b0001????: seg = 3'd4;
      8'b00001???: seg = 3'd3;
      8'b000001??: seg = 3'd2;
      8'b0000001?: seg = 3'd1;
      default:     seg = 3'd0;
    endcase
    sh  = int'(seg) + 3;
    man = mag[sh +: 4];
    return ~{neg, seg, man};
  endfunction

  // inverted mu-law code -> linear two's complement
  function automatic logic [LIN_W-1:0] mu_expand(input logic [PCM_W-1:0] c);
    logic [PCM_W-1:0] k;
    logic [LIN_W-1:0] t;
    k = ~c;
    t = ({{(LIN_W-7){1'b0}}, k[3:0], 3'b000} + LIN_W'(MU_BIAS)) << k[6:4];
    return k[7] ? (LIN_W'(MU_BIAS) - t) : (t - LIN_W'(MU_BIAS));
  endfunction
endpackage

// File: rtl/vlb_mode_latch.sv
module vlb_mode_latch
  import vlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic [MODE_W-1:0] mode_req,
  input  logic              bypass_req,
  output lb_mode_e          mode_act,
  output logic              bypass_act
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_act   <= LB_NORMAL;
      bypass_act <= 1'b0;
    end else if (frame_sync) begin
      mode_act   <= lb_mode_e'(mode_req);
      bypass_act <= bypass_req;
    end
  end

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_sync) |-> ($stable(mode_act) && $stable(bypass_act)));
  p_mode_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (mode_act == lb_mode_e'($past(mode_req))));
endmodule

// File: rtl/vlb_rx_expand.sv
module vlb_rx_expand
  import vlb_pkg::*;
#(
  parameter int W = LIN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  input  logic         bypass,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  logic [W-1:0] expanded;
  assign expanded = mu_expand(in_d[PCM_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      out_d <= '0;
    end else begin
      out_v <= in_v;
      if (in_v) out_d <= bypass ? in_d : expanded;
    end
  end

  p_rx_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_v |=> out_v);
  p_rx_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_v && bypass) |=> (out_d == $past(in_d)));
endmodule

// File: rtl/vlb_tx_framer.sv
module vlb_tx_framer
  import vlb_pkg::*;
#(
  parameter int W = LIN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_sync,
  input  logic         src_v,
  input  logic [W-1:0] src_d,
  input  logic         bypass,
  output logic         tx_v,
  output logic [W-1:0] tx_d
);
  logic         hold_v;
  logic [W-1:0] hold_d;
  logic [W-1:0] coded;

  assign coded = bypass ? src_d : {{(W-PCM_W){1'b0}}, mu_compress(src_d)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
      tx_v   <= 1'b0;
      tx_d   <= '0;
    end else begin
      tx_v <= frame_sync && hold_v;
      if (frame_sync && hold_v) tx_d <= hold_d;
      if (src_v) begin
        hold_v <= 1'b1;
        hold_d <= coded;
      end else if (frame_sync) begin
        hold_v <= 1'b0;
      end
    end
  end

  p_tx_at_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_v |-> $past(frame_sync));
  p_tx_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_v |=> !tx_v);
  p_tx_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && !hold_v) |=> !tx_v);
endmodule

// File: rtl/vlb_router.sv
module vlb_router
  import vlb_pkg::*;
#(
  parameter int W = LIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic [MODE_W-1:0] mode_req,
  input  logic              bypass_req,
  input  logic              rx_pcm_valid,
  input  logic [W-1:0]      rx_pcm_data,
  output logic              dac_valid,
  output logic [W-1:0]      dac_sample,
  input  logic              adc_valid,
  input  logic [W-1:0]      adc_sample,
  output logic              tx_pcm_valid,
  output logic [W-1:0]      tx_pcm_data
);
  lb_mode_e     mode_act;
  logic         bypass_act;
  logic         rx_lin_v;
  logic [W-1:0] rx_lin_d;
  logic         adc_q_v;
  logic [W-1:0] adc_q_d;
  logic         hyb_v;
  logic [W-1:0] hyb_d;
  logic         tx_src_v;
  logic [W-1:0] tx_src_d;
  logic         atest_sel;

  vlb_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .mode_req(mode_req), .bypass_req(bypass_req),
    .mode_act(mode_act), .bypass_act(bypass_act)
  );

  vlb_rx_expand #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_v(rx_pcm_valid), .in_d(rx_pcm_data),
    .bypass(bypass_act), .out_v(rx_lin_v), .out_d(rx_lin_d)
  );

  // converter-side register and hybrid-path register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adc_q_v <= 1'b0;
      adc_q_d <= '0;
      hyb_v   <= 1'b0;
      hyb_d   <= '0;
    end else begin
      adc_q_v <= adc_valid;
      if (adc_valid) adc_q_d <= adc_sample;
      hyb_v <= dac_valid && (mode_act == LB_FULL);
      if (dac_valid) hyb_d <= dac_sample;
    end
  end

  assign atest_sel  = (mode_act == LB_ATEST);
  assign dac_valid  = atest_sel ? adc_q_v : rx_lin_v;
  assign dac_sample = atest_sel ? adc_q_d : rx_lin_d;

  always_comb begin
    tx_src_v = 1'b0;
    tx_src_d = adc_q_d;
    unique case (mode_act)
      LB_NORMAL:  begin tx_src_v = adc_q_v;  tx_src_d = adc_q_d;  end
      LB_ATEST:   begin tx_src_v = 1'b0;     tx_src_d = adc_q_d;  end
      LB_DIGITAL: begin tx_src_v = rx_lin_v; tx_src_d = rx_lin_d; end
      LB_FULL:    begin tx_src_v = hyb_v;    tx_src_d = hyb_d;    end
      default:    begin tx_src_v = 1'b0;     tx_src_d = adc_q_d;  end
    endcase
  end

  vlb_tx_framer #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .src_v(tx_src_v), .src_d(tx_src_d), .bypass(bypass_act),
    .tx_v(tx_pcm_valid), .tx_d(tx_pcm_data)
  );

  p_atest_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (atest_sel && adc_valid) |=> (dac_valid && !tx_src_v));
  p_atest_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (atest_sel && adc_valid && !frame_sync) |=> (dac_sample == $past(adc_sample)));
  p_digital_tap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == LB_DIGITAL && rx_lin_v) |-> (tx_src_v && tx_src_d == dac_sample));
  p_full_hyb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == LB_FULL && dac_valid && !frame_sync) |=> (hyb_v && hyb_d == $past(dac_sample)));
  p_pcm_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && !bypass_act && !adc_valid && !rx_pcm_valid && !tx_src_v
     && mode_act == LB_NORMAL && !adc_q_v) |=> (tx_pcm_valid -> tx_pcm_data[W-1:PCM_W] == '0));
endmodule

// File: tb/vlb_router_test.sv
module vlb_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_sync = 1'b0;
  logic [1:0]  mode_req = 2'b00;
  logic        bypass_req = 1'b0;
  logic        rx_pcm_valid = 1'b0;
  logic [15:0] rx_pcm_data = '0;
  logic        dac_valid;
  logic [15:0] dac_sample;
  logic        adc_valid = 1'b0;
  logic [15:0] adc_sample = '0;
  logic        tx_pcm_valid;
  logic [15:0] tx_pcm_data;

  int vec_cnt = 0;
  int bad_cnt = 0;

  always #5 clk = ~clk;

  vlb_router uut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .mode_req(mode_req),
    .bypass_req(bypass_req), .rx_pcm_valid(rx_pcm_valid), .rx_pcm_data(rx_pcm_data),
    .dac_valid(dac_valid), .dac_sample(dac_sample), .adc_valid(adc_valid),
    .adc_sample(adc_sample), .tx_pcm_valid(tx_pcm_valid), .tx_pcm_data(tx_pcm_data)
  );

  // reference mu-law, written from the requirement text (R8, R9)
  function automatic logic [7:0] ref_enc(input int x);
    int m, seg, man, neg;
    neg = (x < 0) ? 1 : 0;
    m = neg ? -x : x;
    if (m > 32635) m = 32635;
    m = m + 132;
    seg = 0;
    for (int s = 7; s >= 0; s--) begin
      if (m >= (128 << s)) begin seg = s; break; end
    end
    man = (m / (8 << seg)) % 16;
    return 8'(255 - (neg * 128 + seg * 16 + man));
  endfunction

  function automatic logic [15:0] ref_dec(input logic [7:0] c);
    int k, mag;
    k = 255 - int'(c);
    mag = ((k % 16) * 8 + 132) * (1 << ((k / 16) % 8)) - 132;
    return (k >= 128) ? 16'(-mag) : 16'(mag);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vec_cnt++;
    if (got !== exp) begin
      bad_cnt++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // sync pulse; at return the emission from the closed frame is visible
  task automatic sync(input logic [1:0] m, input logic byp);
    @(negedge clk);
    frame_sync = 1'b1; mode_req = m; bypass_req = byp;
    @(negedge clk);
    frame_sync = 1'b0;
  endtask

  task automatic rx_send(input logic [15:0] d);
    @(negedge clk);
    rx_pcm_valid = 1'b1; rx_pcm_data = d;
    @(negedge clk);
    rx_pcm_valid = 1'b0;
  endtask

  task automatic adc_send(input logic [15:0] d);
    @(negedge clk);
    adc_valid = 1'b1; adc_sample = d;
    @(negedge clk);
    adc_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 dac_valid", 32'(dac_valid), 32'd0);
    check("R1 tx_valid", 32'(tx_pcm_valid), 32'd0);
    // default normal mode, bypass off: A/D sample compressed
    adc_send(16'd1000);
    idle(4);
    sync(2'b00, 1'b0);
    check("R1 default normal tx_valid", 32'(tx_pcm_valid), 32'd1);
    check("R1 default compress", 32'(tx_pcm_data), 32'(ref_enc(1000)));
    @(negedge clk);
    check("R10 single pulse", 32'(tx_pcm_valid), 32'd0);
    idle(4);
    sync(2'b00, 1'b0);
    check("R1 empty frame silent", 32'(tx_pcm_valid), 32'd0);
  endtask

  task automatic t_normal;
    int vals[4] = '{0, 32767, -32768, -517};
    logic [7:0] codes[3] = '{8'h80, 8'h00, 8'h9C};
    for (int i = 0; i < 4; i++) begin
      adc_send(16'(vals[i]));
      idle(4);
      sync(2'b00, 1'b0);
      check("R8 compress", 32'(tx_pcm_data), 32'(ref_enc(vals[i])));
      check("R7 upper zero", 32'(tx_pcm_data[15:8]), 32'd0);
    end
    check("R8 zero->FF", 32'(ref_enc(0)), 32'hFF);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_pcm_valid = 1'b1; rx_pcm_data = {8'hA5, codes[i]};
      @(negedge clk);
      rx_pcm_valid = 1'b0;
      check("R3 dac_valid", 32'(dac_valid), 32'd1);
      check("R9 expand", 32'(dac_sample), 32'(ref_dec(codes[i])));
    end
    check("R9 80 -> 32124", 32'(ref_dec(8'h80)), 32'd32124);
    idle(4);
    sync(2'b00, 1'b0);
    check("R3 rx not looped", 32'(tx_pcm_valid), 32'd0);
  endtask

  task automatic t_analog;
    sync(2'b01, 1'b0);
    idle(2);
    adc_send(16'h4321);
    check("R4 dac_valid", 32'(dac_valid), 32'd1);
    check("R4 dac data", 32'(dac_sample), 32'h4321);
    // mid-frame request change must not take effect (R2)
    mode_req = 2'b10;
    rx_send(16'h0055);
    check("R2 no early digital", 32'(dac_valid), 32'd0);
    idle(4);
    sync(2'b01, 1'b0);
    check("R4 tx silent", 32'(tx_pcm_valid), 32'd0);
  endtask

  task automatic t_digital;
    logic [7:0] codes[4] = '{8'h00, 8'h80, 8'h3C, 8'hE7};
    sync(2'b10, 1'b0);
    for (int i = 0; i < 4; i++) begin
      rx_send({8'h00, codes[i]});
      check("R5 dac gets rx", 32'(dac_sample), 32'(ref_dec(codes[i])));
      idle(4);
      sync(2'b10, 1'b0);
      check("R5 tx_valid", 32'(tx_pcm_valid), 32'd1);
      check("R5 tx equals rx", 32'(tx_pcm_data), 32'(codes[i]));
    end
    rx_send(16'h007F);
    idle(4);
    sync(2'b10, 1'b0);
    check("R9 neg zero returns FF", 32'(tx_pcm_data), 32'hFF);
    // A/D ignored in digital loop
    adc_send(16'h1111);
    idle(4);
    sync(2'b11, 1'b0);
    check("R5 adc ignored", 32'(tx_pcm_valid), 32'd0);
  endtask

  task automatic t_full;
    logic [7:0] codes[3] = '{8'h12, 8'hFE, 8'h80};
    for (int i = 0; i < 3; i++) begin
      rx_send({8'h00, codes[i]});
      idle(5);
      sync(2'b11, 1'b0);
      check("R6 tx_valid", 32'(tx_pcm_valid), 32'd1);
      check("R6 tx equals rx", 32'(tx_pcm_data), 32'(codes[i]));
    end
  endtask

  task automatic t_bypass;
    sync(2'b00, 1'b1);
    rx_send(16'hBEEF);
    check("R7 dac linear", 32'(dac_sample), 32'hBEEF);
    adc_send(16'h1234);
    idle(4);
    // switch bypass off and digital loop at the same sync (R11)
    sync(2'b10, 1'b0);
    check("R11 old bypass kept", 32'(tx_pcm_data), 32'h1234);
    rx_send(16'h0033);
    idle(4);
    sync(2'b10, 1'b1);
    check("R11 old pcm kept", 32'(tx_pcm_data), 32'h0033);
    rx_send(16'h8001);
    idle(4);
    sync(2'b00, 1'b0);
    check("R7 linear digital loop", 32'(tx_pcm_data), 32'h8001);
  endtask

  initial begin
    #2000000;
    bad_cnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_normal();
    t_analog();
    t_digital();
    t_full();
    t_bypass();
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end
endmodule